// File: doc/BRIEF.md
# Synchronous Burst-Read Bus Controller

This controller fetches one block of 32-bit words from a memory over a 64-bit synchronous bus and hands it to a requester. Each request names a block base address and one of two block sizes: 4 words or 16 words. The controller first drives the address for one cycle. It then waits out the fixed first memory access. After that it receives the block two words per bus cycle, in groups of four words.

When a block has several groups, the read of each later group runs in the background while the previous group crosses the bus. Each later group therefore costs only its fixed follow-on access time. After the last transfer the bus is held quiet for a fixed number of idle cycles. The controller then pulses a completion strobe. A built-in cycle counter reports how long the block took: 45 cycles for a 4-word block and 57 for a 16-word block with the default timing. Size codes that name neither block size are refused and flagged.

Top module: `burst_read_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready` is 1, `bus_addr_valid`, `bus_rd`, `out_valid`, `block_done` and `req_err` are 0, and `cycle_count` is 0.
- R2: A request is taken at a rising edge where `req_ready` and `req_valid` are 1 and `req_size` is 2'b00 (4 words) or 2'b01 (16 words). In the next cycle `bus_addr_valid` is 1 for exactly one cycle, and `bus_addr` carries the request address.
- R3: The first data beat (`bus_rd` = 1) comes 40 cycles after the address cycle, in block cycle 42 when the address cycle counts as cycle 1.
- R4: Each 4-word group is received as two consecutive `bus_rd` beats. `bus_beat` numbers the 64-bit beats of the block from 0 upward, so beat b carries words 2b and 2b+1.
- R5: Each later group starts 4 cycles after the start of the previous group. This leaves 2 bus-quiet cycles, during which the next group is being read.
- R6: After the last beat the bus stays quiet for 2 cycles, and `block_done` pulses in the second of them. For a 4-word block this is block cycle 45; for a 16-word block it is block cycle 57.
- R7: `cycle_count` is 1 in the address cycle and rises by 1 in each following cycle of the block. It therefore equals 45 or 57 while `block_done` is 1, and it holds that value while idle.
- R8: One cycle after each `bus_rd` beat, `out_valid` is 1 and `out_data` carries the 64 bits the memory drove on `bus_rdata` in that beat.
- R9: A request with `req_size` 2'b10 or 2'b11 is not taken. `req_err` is 1 in the following cycle only, the controller stays idle with no address cycle, and `cycle_count` keeps its value.
- R10: `req_ready` is 0 from the address cycle through the `block_done` cycle, and `req_valid` has no effect in that span.
- R11: `req_ready` is 1 in the cycle after `block_done`, so a request held there starts a new block at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Block request |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Block base byte address |
| req_size | input | 2 | 00: 4 words, 01: 16 words, others refused |
| req_err | output | 1 | One-cycle strobe for a refused size code |
| bus_addr_valid | output | 1 | Address cycle on the bus |
| bus_addr | output | ADDR_W | Latched block address |
| bus_rd | output | 1 | Data beat cycle |
| bus_beat | output | BEAT_W | Beat index within the block |
| bus_rdata | input | 2*WORD_W | Data driven by the memory during a beat |
| out_valid | output | 1 | Registered data valid |
| out_data | output | 2*WORD_W | Registered data beat |
| block_done | output | 1 | One-cycle block completion strobe |
| cycle_count | output | CNT_W | Cycles spent on the current or last block |

## Verification
The bench runs a lone 4-word block and a lone 16-word block. These separate the single-group timing from the overlapped multi-group timing and show the 45-cycle and 57-cycle totals. It then sends both refused size codes, which shows that they leave the controller and its cycle count alone. A request pulsed in the middle of a block shows that it is ignored. Two requests held back to back, one of each size, show that the controller restarts in the first idle cycle and that the address latch takes the new address. Every cycle is compared with a behavioural timing model.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam logic [1:0] SZ_SMALL = 2'b00;
  localparam logic [1:0] SZ_LARGE = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACCESS,
    ST_XFER,
    ST_GAP,
    ST_TAIL
  } burst_state_e;

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ACCESS_FIRST = 40,
  parameter int ACCESS_NEXT  = 4,
  parameter int IDLE_CYC     = 2,
  parameter int BEATS        = 2,
  parameter int GRP_SMALL    = 1,
  parameter int GRP_LARGE    = 4,
  parameter int BEAT_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  output logic              req_ready,
  output logic              accept,
  output logic              req_err,
  output logic              bus_addr_valid,
  output logic              bus_rd,
  output logic [BEAT_W-1:0] bus_beat,
  output logic              block_done,
  output logic              advance
);

  localparam int GAP_CYC = ACCESS_NEXT - BEATS;
  localparam int PH_W    = $clog2(ACCESS_FIRST + 1);
  localparam int GRP_W   = (GRP_LARGE > 1) ? $clog2(GRP_LARGE) : 1;

  burst_state_e      state_q, state_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              err_q, err_d;
  logic              size_ok;

  assign size_ok = (req_size == SZ_SMALL) || (req_size == SZ_LARGE);

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    grp_d   = grp_q;
    beat_d  = beat_q;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (size_ok) begin
            state_d = ST_ADDR;
            beat_d  = '0;
            grp_d   = (req_size == SZ_SMALL) ? GRP_W'(GRP_SMALL - 1)
                                             : GRP_W'(GRP_LARGE - 1);
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_ADDR: begin
        state_d = ST_ACCESS;
        ph_d    = PH_W'(ACCESS_FIRST - 1);
      end
      ST_ACCESS: begin
        if (ph_q == '0) begin
          state_d = ST_XFER;
          ph_d    = PH_W'(BEATS - 1);
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      ST_XFER: begin
        beat_d = beat_q + 1'b1;
        if (ph_q == '0) begin
          if (grp_q == '0) begin
            state_d = ST_TAIL;
            ph_d    = PH_W'(IDLE_CYC - 1);
          end else begin
            state_d = ST_GAP;
            ph_d    = PH_W'(GAP_CYC - 1);
            grp_d   = grp_q - 1'b1;
          end
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (ph_q == '0) begin
          state_d = ST_XFER;
          ph_d    = PH_W'(BEATS - 1);
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      ST_TAIL: begin
        if (ph_q == '0) state_d = ST_IDLE;
        else            ph_d    = ph_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      grp_q   <= '0;
      beat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      grp_q   <= grp_d;
      beat_q  <= beat_d;
      err_q   <= err_d;
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign accept         = req_ready && req_valid && size_ok;
  assign req_err        = err_q;
  assign bus_addr_valid = (state_q == ST_ADDR);
  assign bus_rd         = (state_q == ST_XFER);
  assign bus_beat       = beat_q;
  assign block_done     = (state_q == ST_TAIL) && (ph_q == '0);
  assign advance        = (state_q != ST_IDLE) && !block_done;

  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_beat[0]) |=> (bus_rd && bus_beat == $past(bus_beat) + 1'b1)); // R4
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> req_ready); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> req_ready); // R11

endmodule

// File: rtl/burst_cyc_count.sv
module burst_cyc_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = start || advance;

  always_comb begin
    cnt_d = cnt_q;
    if (start)        cnt_d = CNT_W'(1);
    else if (advance) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (count == $past(count) + 1'b1)); // R7
  AST_CNT_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == CNT_W'(1))); // R7

endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [DATA_W-1:0] rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vld_q <= 1'b0;
    else           vld_q <= beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (beat) dat_q <= rdata;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WORD_W       = 32,
  parameter int BUS_WORDS    = 2,
  parameter int GROUP_WORDS  = 4,
  parameter int SMALL_WORDS  = 4,
  parameter int LARGE_WORDS  = 16,
  parameter int ACCESS_FIRST = 40,
  parameter int ACCESS_NEXT  = 4,
  parameter int IDLE_CYC     = 2,
  parameter int CNT_W        = 8,
  localparam int DATA_W      = WORD_W * BUS_WORDS,
  localparam int MAX_BEATS   = LARGE_WORDS / BUS_WORDS,
  localparam int BEAT_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              req_err,
  output logic              bus_addr_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic [BEAT_W-1:0] bus_beat,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              block_done,
  output logic [CNT_W-1:0]  cycle_count
);

  localparam int BEATS     = GROUP_WORDS / BUS_WORDS;
  localparam int GRP_SMALL = SMALL_WORDS / GROUP_WORDS;
  localparam int GRP_LARGE = LARGE_WORDS / GROUP_WORDS;

  logic              accept;
  logic              advance;
  logic [ADDR_W-1:0] addr_q;

  burst_seq #(
    .ACCESS_FIRST (ACCESS_FIRST),
    .ACCESS_NEXT  (ACCESS_NEXT),
    .IDLE_CYC     (IDLE_CYC),
    .BEATS        (BEATS),
    .GRP_SMALL    (GRP_SMALL),
    .GRP_LARGE    (GRP_LARGE),
    .BEAT_W       (BEAT_W)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_size       (req_size),
    .req_ready      (req_ready),
    .accept         (accept),
    .req_err        (req_err),
    .bus_addr_valid (bus_addr_valid),
    .bus_rd         (bus_rd),
    .bus_beat       (bus_beat),
    .block_done     (block_done),
    .advance        (advance)
  );

  burst_cyc_count #(.CNT_W(CNT_W)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .advance (advance),
    .count   (cycle_count)
  );

  burst_capture #(.DATA_W(DATA_W)) i_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (bus_rd),
    .rdata     (bus_rdata),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  assign bus_addr = addr_q;

  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_valid |=> !bus_addr_valid); // R2
  AST_ADDR_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bus_addr_valid && bus_addr == $past(req_addr))); // R2
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (out_valid && out_data == $past(bus_rdata))); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_valid || bus_rd || block_done) |-> !req_ready); // R10

endmodule

// File: tb/test_burst_read_ctrl.sv
`timescale 1ns/1ps
module test_burst_read_ctrl;

  localparam int FIRST_RD = 42;
  localparam int GRP_SPAN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, req_err, bus_addr_valid, bus_rd, out_valid, block_done;
  logic [31:0] bus_addr;
  logic [2:0]  bus_beat;
  logic [63:0] bus_rdata, out_data;
  logic [7:0]  cycle_count;

  int checks = 0;
  int failures = 0;
  bit chk_en = 1'b0;

  always #2 clk = ~clk;

  burst_read_ctrl i_burst_read_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_err(req_err),
    .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_beat(bus_beat), .bus_rdata(bus_rdata), .out_valid(out_valid),
    .out_data(out_data), .block_done(block_done), .cycle_count(cycle_count)
  );

  function automatic logic [63:0] mem_word(input logic [31:0] base, input int beat);
    logic [31:0] a;
    a = base + 32'(beat * 8);
    return {a + 32'd4 ^ 32'hA5A5_0000, a ^ 32'h5A5A_0000};
  endfunction

  // memory model: latches the block address, drives data in beat cycles
  logic [31:0] mem_base = '0;
  always @(posedge clk) if (bus_addr_valid) mem_base <= bus_addr;
  assign bus_rdata = bus_rd ? mem_word(mem_base, int'(bus_beat)) : 64'h0;

  // behavioural timing model
  int          m_cyc = 0;
  int          m_groups = 0;
  int          m_count = 0;
  logic [31:0] m_addr = '0;
  bit          m_err = 1'b0;
  bit          m_ov = 1'b0;
  logic [63:0] m_od = '0;

  function automatic bit exp_rd(input int c, input int g);
    if (c < FIRST_RD) return 1'b0;
    return ((c - FIRST_RD) / GRP_SPAN < g) && ((c - FIRST_RD) % GRP_SPAN < 2);
  endfunction

  function automatic int exp_beat(input int c);
    return ((c - FIRST_RD) / GRP_SPAN) * 2 + (c - FIRST_RD) % GRP_SPAN;
  endfunction

  function automatic int done_cyc(input int g);
    return FIRST_RD - 1 + GRP_SPAN * g;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_count = 0; m_err = 0; m_ov = 0;
    end else begin
      m_ov = exp_rd(m_cyc, m_groups);
      if (m_ov) m_od = mem_word(m_addr, exp_beat(m_cyc));
      m_err = (m_cyc == 0) && req_valid && (req_size > 2'd1);
      if (m_cyc == 0) begin
        if (req_valid && req_size <= 2'd1) begin
          m_cyc = 1; m_count = 1; m_addr = req_addr;
          m_groups = (req_size == 2'd0) ? 1 : 4;
        end
      end else if (m_cyc == done_cyc(m_groups)) begin
        m_cyc = 0;
      end else begin
        m_cyc++; m_count++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      check(req_ready == (m_cyc == 0), "R10 req_ready", req_ready, m_cyc == 0);
      check(bus_addr_valid == (m_cyc == 1), "R2 addr cycle", bus_addr_valid, m_cyc == 1);
      if (m_cyc == 1) check(bus_addr == m_addr, "R2 bus_addr", bus_addr, m_addr);
      check(bus_rd == exp_rd(m_cyc, m_groups), "R3/R5 beat timing", bus_rd, exp_rd(m_cyc, m_groups));
      if (bus_rd && exp_rd(m_cyc, m_groups))
        check(int'(bus_beat) == exp_beat(m_cyc), "R4 beat index", bus_beat, exp_beat(m_cyc));
      check(block_done == (m_cyc != 0 && m_cyc == done_cyc(m_groups)), "R6 block_done",
            block_done, m_cyc != 0 && m_cyc == done_cyc(m_groups));
      check(int'(cycle_count) == m_count, "R7 cycle_count", cycle_count, m_count);
      check(out_valid == m_ov, "R8 out_valid", out_valid, m_ov);
      if (out_valid && m_ov) check(out_data == m_od, "R8 out_data", out_data, m_od);
      check(req_err == m_err, "R9 req_err", req_err, m_err);
    end
  end

  task automatic send(input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int total);
    total = 0;
    while (block_done !== 1'b1) @(negedge clk);
    total = int'(cycle_count);
  endtask

  initial begin
    int total;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1 && bus_rd == 1'b0 && bus_addr_valid == 1'b0, "R1 idle outputs",
          {req_ready, bus_rd, bus_addr_valid}, 3'b100);
    check(cycle_count == 8'd0 && !block_done && !req_err && !out_valid, "R1 count and strobes",
          cycle_count, 0);
    chk_en = 1'b1;

    // 4-word block
    send(32'h0000_1000, 2'b00);
    wait_done(total);
    check(total == 45, "R6 4-word total", total, 45);
    repeat (3) @(negedge clk);
    check(cycle_count == 8'd45, "R7 count held", cycle_count, 45);

    // 16-word block
    send(32'h0000_2040, 2'b01);
    wait_done(total);
    check(total == 57, "R6 16-word total", total, 57);
    repeat (2) @(negedge clk);

    // refused sizes
    send(32'h0000_3000, 2'b10);
    @(negedge clk);
    check(req_ready && !bus_addr_valid && cycle_count == 8'd57, "R9 size 10 refused",
          cycle_count, 57);
    send(32'h0000_3100, 2'b11);
    @(negedge clk);
    check(req_ready && !bus_addr_valid && cycle_count == 8'd57, "R9 size 11 refused",
          cycle_count, 57);

    // request pulsed mid-block is ignored
    send(32'h0000_4000, 2'b00);
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_9990; req_size = 2'b01;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(total);
    check(total == 45, "R10 ignored request keeps 4-word timing", total, 45);
    @(negedge clk);
    check(req_ready && !bus_addr_valid, "R10 no block from ignored request", bus_addr_valid, 0);

    // back-to-back: request held through done
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_5000; req_size = 2'b01;
    @(negedge clk);
    req_addr = 32'h0000_6000; req_size = 2'b00;
    wait_done(total);
    check(total == 57, "R11 first of pair", total, 57);
    @(negedge clk);
    check(req_ready == 1'b1, "R11 ready after done", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(bus_addr_valid && bus_addr == 32'h0000_6000, "R11 restart at once", bus_addr, 32'h6000);
    wait_done(total);
    check(total == 45, "R11 second of pair", total, 45);
    repeat (4) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule